// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits between one bus master and a 32-bit word port that leads to memory or peripherals. Two fixed 1 MB regions each have a 32 MB alias window. In the window, every bit of the region has its own 32-bit word. A word access to an alias address becomes an operation on that one bit.

An alias read fetches the word that holds the bit and returns the bit in bit 0, with every other bit zero. An alias write reads the word, replaces the one bit with bit 0 of the write data, and writes the word back. The downstream port stays locked from the read until the write-back is accepted. Any address outside both alias windows goes downstream unchanged, and that includes addresses inside the regions themselves.

On the master side the request is held valid until the unit raises `m_ready` for one cycle, and read data and the error flag are valid in that cycle. On the downstream side a request completes when `d_valid` and `d_ready` are both high. For a read, the data appears on `d_rdata` one cycle after acceptance.

Top module: `bitband_unit`

## Requirements
- R1: An aligned read of an alias address returns the selected bit of the target word in m_rdata bit 0, with m_rdata bits 31..1 equal to zero and m_err low.
- R2: An aligned write to an alias address changes only the target bit of the target word, setting it to bit 0 of m_wdata; bits 31..1 of m_wdata are ignored.
- R3: Window 0 covers alias addresses 0x2200_0000..0x23FF_FFFF and maps them onto region 0x2000_0000. Window 1 covers 0x4200_0000..0x43FF_FFFF and maps them onto region 0x4000_0000. For offset off = addr − window base, the target word is region base + (off >> 7)·4 and the bit position is off[6:2].
- R4: During an alias write, d_lock is high from the first cycle of the downstream read through the cycle in which the write-back is accepted, and low afterwards. The read comes first, then the write. m_ready stays low while d_lock is high. Plain accesses never raise d_lock.
- R5: An alias access with addr[1:0] ≠ 0 makes no downstream request and completes with m_err high and m_rdata zero.
- R6: An access outside both alias windows goes downstream with its address and write data unchanged. A read returns the downstream word, and m_err is low.
- R7: m_ready is high for exactly one cycle per request. Counted in clock edges from the edge that accepts the request to the edge that leaves m_ready high, the latency is 1 for a misaligned alias access, 2 for a plain write, 3 for any read and 4 for an alias write. Each cycle that downstream holds d_ready low while d_valid is high adds one.
- R8: While d_valid is high and d_ready is low, d_valid, d_addr, d_write and d_wdata hold their values on the next cycle.
- R9: After reset, m_ready, d_valid and d_lock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| m_valid | input | 1 | Master request present, held until m_ready |
| m_ready | output | 1 | One-cycle completion of the master request |
| m_addr | input | 32 | Master byte address |
| m_write | input | 1 | 1 = write, 0 = read |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Read result, valid with m_ready |
| m_err | output | 1 | Misaligned alias access, valid with m_ready |
| d_valid | output | 1 | Downstream request |
| d_ready | input | 1 | Downstream accepts the request |
| d_addr | output | 32 | Downstream word address |
| d_write | output | 1 | Downstream write flag |
| d_wdata | output | 32 | Downstream write data |
| d_lock | output | 1 | Downstream held for an indivisible read-modify-write |
| d_rdata | input | 32 | Downstream read data, one cycle after acceptance |

## Verification
Each kind of request has a fixed completion time, counted from the accepting edge: one edge for a misaligned alias access, two for a plain write, three for a read and four for an alias write. Every downstream stall cycle adds one edge. The bench counts the stall cycles it sees at each falling edge, adds them to that base, and compares the total with the falling edge at which m_ready is first seen high. It samples data and error there and checks that m_ready is low one cycle later. On every cycle in between, it compares the downstream address and lock against the predicted target.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WAIT,
        ST_WR,
        ST_RESP
    } bb_state_e;

    typedef enum logic [1:0] {
        K_PLAIN_RD,
        K_PLAIN_WR,
        K_ALIAS_RD,
        K_ALIAS_WR
    } bb_kind_e;

endpackage

// File: rtl/bb_decode.sv
module bb_decode #(
    parameter int unsigned AW       = 32,
    parameter int unsigned NWIN     = 2,
    parameter int unsigned WIN_BITS = 25,
    parameter int unsigned BIT_W    = 5,
    parameter int unsigned BYTE_SH  = 2,
    parameter logic [NWIN*AW-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NWIN*AW-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic             misalign,
    output logic [AW-1:0]    word_addr,
    output logic [BIT_W-1:0] bit_idx
);
    localparam int unsigned WORD_SH = BIT_W + BYTE_SH;

    logic [NWIN-1:0]     win_hit;
    logic [AW-1:0]       win_word [NWIN];
    logic [WIN_BITS-1:0] off;

    assign off = addr[WIN_BITS-1:0];

    // one comparator and one address builder per alias window
    for (genvar i = 0; i < NWIN; i++) begin : g_win
        assign win_hit[i]  = addr[AW-1:WIN_BITS] ==
                             ALIAS_BASES[i*AW+WIN_BITS +: AW-WIN_BITS];
        assign win_word[i] = REGION_BASES[i*AW +: AW] +
                             AW'((off >> WORD_SH) << BYTE_SH);
    end

    always_comb begin
        hit       = 1'b0;
        word_addr = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (win_hit[i] && !hit) begin
                hit       = 1'b1;
                word_addr = win_word[i];
            end
        end
    end

    assign bit_idx  = addr[BYTE_SH +: BIT_W];
    assign misalign = hit && (addr[BYTE_SH-1:0] != '0);

endmodule

// File: rtl/bb_merge.sv
module bb_merge #(
    parameter int unsigned DW    = 32,
    parameter int unsigned BIT_W = 5
) (
    input  logic [DW-1:0]    word,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [DW-1:0]    picked,
    output logic [DW-1:0]    merged
);
    assign picked = {{(DW-1){1'b0}}, word[bit_idx]};

    // per-lane select: only the addressed lane takes the new value
    for (genvar j = 0; j < DW; j++) begin : g_lane
        assign merged[j] = (bit_idx == BIT_W'(j)) ? bit_val : word[j];
    end

endmodule

// File: rtl/bb_seq.sv
module bb_seq
    import bb_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned BIT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_valid,
    input  logic             m_write,
    input  logic [AW-1:0]    m_addr,
    input  logic [DW-1:0]    m_wdata,
    input  logic             dec_hit,
    input  logic             dec_misalign,
    input  logic [AW-1:0]    dec_word_addr,
    input  logic [BIT_W-1:0] dec_bit_idx,
    output logic [BIT_W-1:0] mg_bit_idx,
    output logic             mg_bit_val,
    input  logic [DW-1:0]    mg_picked,
    input  logic [DW-1:0]    mg_merged,
    output logic             m_ready,
    output logic [DW-1:0]    m_rdata,
    output logic             m_err,
    output logic             d_valid,
    input  logic             d_ready,
    output logic [AW-1:0]    d_addr,
    output logic             d_write,
    output logic [DW-1:0]    d_wdata,
    output logic             d_lock,
    input  logic [DW-1:0]    d_rdata
);
    typedef struct packed {
        bb_state_e        state;
        bb_kind_e         kind;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [BIT_W-1:0] bit_idx;
        logic [DW-1:0]    rdata;
        logic             err;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (m_valid) begin
                    r_d.wdata   = m_wdata;
                    r_d.bit_idx = dec_bit_idx;
                    r_d.rdata   = '0;
                    r_d.err     = 1'b0;
                    if (dec_hit) begin
                        r_d.addr = dec_word_addr;
                        r_d.kind = m_write ? K_ALIAS_WR : K_ALIAS_RD;
                    end else begin
                        r_d.addr = m_addr;
                        r_d.kind = m_write ? K_PLAIN_WR : K_PLAIN_RD;
                    end
                    if (dec_misalign) begin
                        r_d.err   = 1'b1;
                        r_d.state = ST_RESP;
                    end else if (!dec_hit && m_write) begin
                        r_d.state = ST_WR;
                    end else begin
                        r_d.state = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (d_ready) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (r_q.kind == K_ALIAS_WR) begin
                    r_d.wdata = mg_merged;
                    r_d.state = ST_WR;
                end else begin
                    r_d.rdata = (r_q.kind == K_ALIAS_RD) ? mg_picked : d_rdata;
                    r_d.state = ST_RESP;
                end
            end
            ST_WR: begin
                if (d_ready) r_d.state = ST_RESP;
            end
            ST_RESP: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.kind  <= K_PLAIN_RD;
        end else begin
            r_q <= r_d;
        end
    end

    assign mg_bit_idx = r_q.bit_idx;
    assign mg_bit_val = r_q.wdata[0];

    assign m_ready = (r_q.state == ST_RESP);
    assign m_rdata = r_q.rdata;
    assign m_err   = r_q.err;
    assign d_valid = (r_q.state == ST_RD) || (r_q.state == ST_WR);
    assign d_write = (r_q.state == ST_WR);
    assign d_addr  = r_q.addr;
    assign d_wdata = r_q.wdata;
    assign d_lock  = (r_q.kind == K_ALIAS_WR) &&
                     ((r_q.state == ST_RD) || (r_q.state == ST_WAIT) ||
                      (r_q.state == ST_WR));

    // completion is a single-cycle pulse
    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_ready |=> !m_ready);

    // a stalled downstream request is held unchanged
    assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid && !d_ready |=> d_valid && $stable(d_addr) && $stable(d_write)
                                && $stable(d_wdata));

    // a lock always opens with the read phase
    assert_lock_opens_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_lock) |-> d_valid && !d_write);

    // lock drops right after the write-back is accepted
    assert_lock_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        d_lock && d_valid && d_write && d_ready |=> !d_lock);

    // the master is not completed while the port is locked
    assert_no_resp_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        d_lock |-> !m_ready);

    // an error response carries no data and no downstream traffic
    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_ready && m_err |-> (m_rdata == '0) && !d_valid);

    // alias reads only ever return a value in bit 0
    assert_alias_lsb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        m_ready && !m_err && (r_q.kind == K_ALIAS_RD) |-> m_rdata[DW-1:1] == '0);

endmodule

// File: rtl/bitband_unit.sv
module bitband_unit #(
    parameter int unsigned AW       = 32,
    parameter int unsigned DW       = 32,
    parameter int unsigned NWIN     = 2,
    parameter int unsigned WIN_BITS = 25,
    parameter logic [NWIN*AW-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NWIN*AW-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_valid,
    output logic          m_ready,
    input  logic [AW-1:0] m_addr,
    input  logic          m_write,
    input  logic [DW-1:0] m_wdata,
    output logic [DW-1:0] m_rdata,
    output logic          m_err,
    output logic          d_valid,
    input  logic          d_ready,
    output logic [AW-1:0] d_addr,
    output logic          d_write,
    output logic [DW-1:0] d_wdata,
    output logic          d_lock,
    input  logic [DW-1:0] d_rdata
);
    localparam int unsigned BIT_W   = $clog2(DW);
    localparam int unsigned BYTE_SH = $clog2(DW / 8);

    logic             dec_hit;
    logic             dec_misalign;
    logic [AW-1:0]    dec_word_addr;
    logic [BIT_W-1:0] dec_bit_idx;
    logic [BIT_W-1:0] mg_bit_idx;
    logic             mg_bit_val;
    logic [DW-1:0]    mg_picked;
    logic [DW-1:0]    mg_merged;

    bb_decode #(
        .AW          (AW),
        .NWIN        (NWIN),
        .WIN_BITS    (WIN_BITS),
        .BIT_W       (BIT_W),
        .BYTE_SH     (BYTE_SH),
        .ALIAS_BASES (ALIAS_BASES),
        .REGION_BASES(REGION_BASES)
    ) u_decode (
        .addr     (m_addr),
        .hit      (dec_hit),
        .misalign (dec_misalign),
        .word_addr(dec_word_addr),
        .bit_idx  (dec_bit_idx)
    );

    bb_merge #(
        .DW   (DW),
        .BIT_W(BIT_W)
    ) u_merge (
        .word   (d_rdata),
        .bit_idx(mg_bit_idx),
        .bit_val(mg_bit_val),
        .picked (mg_picked),
        .merged (mg_merged)
    );

    bb_seq #(
        .AW   (AW),
        .DW   (DW),
        .BIT_W(BIT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .m_valid      (m_valid),
        .m_write      (m_write),
        .m_addr       (m_addr),
        .m_wdata      (m_wdata),
        .dec_hit      (dec_hit),
        .dec_misalign (dec_misalign),
        .dec_word_addr(dec_word_addr),
        .dec_bit_idx  (dec_bit_idx),
        .mg_bit_idx   (mg_bit_idx),
        .mg_bit_val   (mg_bit_val),
        .mg_picked    (mg_picked),
        .mg_merged    (mg_merged),
        .m_ready      (m_ready),
        .m_rdata      (m_rdata),
        .m_err        (m_err),
        .d_valid      (d_valid),
        .d_ready      (d_ready),
        .d_addr       (d_addr),
        .d_write      (d_write),
        .d_wdata      (d_wdata),
        .d_lock       (d_lock),
        .d_rdata      (d_rdata)
    );

endmodule

// File: tb/bitband_unit_bench.sv
module bitband_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_valid = 1'b0;
    logic        m_ready;
    logic [31:0] m_addr = '0;
    logic        m_write = 1'b0;
    logic [31:0] m_wdata = '0;
    logic [31:0] m_rdata;
    logic        m_err;
    logic        d_valid;
    logic        d_ready = 1'b1;
    logic [31:0] d_addr;
    logic        d_write;
    logic [31:0] d_wdata;
    logic        d_lock;
    logic [31:0] d_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0] mem     [logic [31:0]];
    logic [31:0] ref_mem [logic [31:0]];

    always #4 clk = ~clk;   // 125 MHz

    bitband_unit u_bitband_unit (
        .clk(clk), .rst_n(rst_n),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
        .m_write(m_write), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_err(m_err),
        .d_valid(d_valid), .d_ready(d_ready), .d_addr(d_addr),
        .d_write(d_write), .d_wdata(d_wdata), .d_lock(d_lock), .d_rdata(d_rdata)
    );

    // downstream memory model: writes land on acceptance, read data one cycle later
    always @(posedge clk) begin
        if (d_valid && d_ready) begin
            if (d_write) mem[d_addr] = d_wdata;
            else d_rdata <= mem.exists(d_addr) ? mem[d_addr] : 32'h0;
        end
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        d_ready <= stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    function automatic logic [31:0] rd_ref(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one master request with a behavioural prediction of its outcome
    task automatic access(input logic [31:0] a, input logic w, input logic [31:0] wd);
        bit          is_alias = 1'b0;
        bit          bad = 1'b0;
        logic [31:0] abase = 0, rbase = 0, off, waddr, exp_rd = 0, word;
        int          bitpos = 0, byteoff, lat, cycles = 0, stalls = 0;

        if (a >= 32'h2200_0000 && a < 32'h2400_0000) begin
            is_alias = 1; abase = 32'h2200_0000; rbase = 32'h2000_0000;
        end else if (a >= 32'h4200_0000 && a < 32'h4400_0000) begin
            is_alias = 1; abase = 32'h4200_0000; rbase = 32'h4000_0000;
        end
        if (is_alias) begin
            off     = a - abase;
            bad     = (off % 4) != 0;
            byteoff = int'(off / 32);
            waddr   = rbase + 32'((byteoff / 4) * 4);
            bitpos  = (byteoff % 4) * 8 + int'((off / 4) % 8);
        end else begin
            waddr = a;
        end
        word = rd_ref(waddr);
        if (bad)            lat = 1;
        else if (is_alias)  lat = w ? 4 : 3;
        else                lat = w ? 2 : 3;
        if (!bad) begin
            if (is_alias && w)      begin word[bitpos] = wd[0]; ref_mem[waddr] = word; end
            else if (is_alias)      exp_rd = {31'h0, word[bitpos]};
            else if (w)             ref_mem[waddr] = wd;
            else                    exp_rd = word;
        end

        @(negedge clk);
        m_valid = 1; m_addr = a; m_write = w; m_wdata = wd;
        do begin
            @(posedge clk);
            @(negedge clk);
            cycles++;
            if (d_valid && !d_ready) stalls++;
            if (bad) check(!d_valid, "R5 no downstream", {31'h0, d_valid}, 32'h0);
            else if (d_valid) begin
                check(d_addr == waddr, "R3 downstream address", d_addr, waddr);
                check(d_lock == (is_alias && w), "R4 lock level",
                      {31'h0, d_lock}, {31'h0, is_alias && w});
                if (!is_alias && w)
                    check(d_wdata == wd, "R6 write data", d_wdata, wd);
            end
        end while (!m_ready && cycles < 200);
        check(cycles == lat + stalls, "R7 latency", cycles, lat + stalls);
        check(m_err == bad, "R5 error flag", {31'h0, m_err}, {31'h0, bad});
        if (!w || bad)
            check(m_rdata == exp_rd, is_alias ? "R1 alias read" : "R6 plain read",
                  m_rdata, exp_rd);
        @(posedge clk);
        @(negedge clk);
        m_valid = 0;
        check(!m_ready, "R7 single cycle ready", {31'h0, m_ready}, 32'h0);
        check(rd_mem(waddr) == rd_ref(waddr), is_alias ? "R2 target word" : "R6 stored word",
              rd_mem(waddr), rd_ref(waddr));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!m_ready && !d_valid && !d_lock, "R9 reset outputs",
              {29'h0, m_ready, d_valid, d_lock}, 32'h0);
        rst_n = 1;

        access(32'h2000_0000, 1, 32'h3355_AACC);          // R6 plain write
        access(32'h2000_0000, 0, 0);                      // R6 plain read
        access(32'h2200_0008, 0, 0);                      // R1 bit 2 reads 1
        access(32'h2200_0008, 1, 32'h0);                  // R2 clear bit 2
        access(32'h2000_0000, 0, 0);                      // R2 expect 0x3355AAC8
        check(rd_mem(32'h2000_0000) == 32'h3355_AAC8, "R2 example word",
              rd_mem(32'h2000_0000), 32'h3355_AAC8);
        access(32'h2200_007C, 1, 32'hFFFF_FFFE);          // R2 upper bits ignored
        access(32'h2200_007C, 1, 32'h0000_0001);          // R3 bit 31 set
        access(32'h2200_007C, 0, 0);                      // R1
        access(32'h23FF_FFFC, 1, 32'h1);                  // R3 top of window
        access(32'h200F_FFFC, 0, 0);
        access(32'h4000_0010, 1, 32'h0F0F_0F0F);          // R6 window 1 region
        access(32'h4200_0200 + 32'd12, 0, 0);             // R3 byte 0x10 bit 3
        access(32'h4200_0200 + 32'd16, 1, 32'h1);         // R3 byte 0x10 bit 4
        access(32'h2200_0002, 0, 0);                      // R5 misaligned read
        access(32'h2200_0009, 1, 32'h1);                  // R5 misaligned write
        access(32'h2400_0000, 1, 32'hDEAD_BEEF);          // R6 just past window
        access(32'h2400_0000, 0, 0);

        stall_en = 1'b1;                                  // R8 stalled traffic
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a;
            int          sel = (i * 7 + int'(lfsr[3:0])) % 6;
            case (sel)
                0: a = 32'h2000_0000;
                1: a = 32'h2200_0000 + 32'((i % 32) * 4);
                2: a = 32'h4200_0000 + 32'h200 + 32'((i % 32) * 4);
                3: a = 32'h4000_0010;
                4: a = 32'h2200_0001 + 32'(i % 3);
                default: a = 32'h2200_0100 + 32'((i % 8) * 4);
            endcase
            access(a, (i % 3) != 0, 32'h1357_9BDF * (i + 1));
        end
        finish_run();
    end

endmodule